// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM has an active-low chip select, an active-low write strobe and an active-low output enable, plus an address bus and a shared data bus. A client offers one read or write at a time on a valid/ready port. The sequencer turns each request into a strobe pattern in which every interval is a whole number of clock periods. Those intervals are address setup, bus turnaround, data setup, data hold, read access and recovery, and each is set by a parameter.

For a write, chip select falls first. The write strobe follows, and the write strobe rises before chip select, so the write strobe always closes the write window. Output enable stays inactive for the whole write. The data bus is released for a turnaround period after the write strobe falls, so any RAM output that is still active can switch off before the controller drives the bus. For a read, chip select and output enable fall together. The bus is sampled when the access count runs out, and the captured word is returned with a one-cycle valid pulse.

The data bus is presented as a separate drive value, a drive-enable and a sampled input, which a pad ring joins into the bidirectional pins. All strobe and enable outputs come straight from flip-flops.

Top module: `sram_strobe_seq`

## Requirements
- R1: While reset is held and right after it is released, chip select, write strobe and output enable are high. The data drive-enable is low, ready is high and read-valid is low.
- R2: A write holds chip select low for exactly T_AS + T_WZ + T_DS + T_DH cycles. The write strobe falls T_AS cycles after chip select falls. It rises T_DH cycles before chip select rises, so the write strobe is low only while chip select is low.
- R3: Output enable is high in every cycle in which the write strobe is low or the controller drives the data bus.
- R4: After the write strobe falls, the controller leaves the data bus undriven for exactly T_WZ cycles. It then drives write data for exactly T_DS cycles before the write strobe rises.
- R5: After the write strobe rises, write data stays driven for exactly T_DH cycles. The bus is released when chip select rises, and it is never driven while chip select is high.
- R6: The address bus does not change while chip select is low.
- R7: After any cycle ends, chip select stays high and ready stays low for exactly T_REC cycles. Ready then returns high.
- R8: A read holds chip select and output enable low, with the write strobe high, for exactly T_ACC cycles. The bus value at the last of those cycles is captured and presented on the read data output. Read-valid is high for exactly one cycle, the first cycle after chip select rises.
- R9: A request is taken only on a clock edge where valid and ready are both high. Each request that is taken produces exactly one chip-select pulse, and the request fields are latched at that edge.
- R10: Data written to an address is returned by a later read of that address, including all-zero and all-one words at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | DW | Captured read data |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_addr | output | AW | RAM address |
| sram_dq_out | output | DW | Value to drive on the RAM data pins |
| sram_dq_oe | output | 1 | Drive-enable for the RAM data pins |
| sram_dq_in | input | DW | Value sampled from the RAM data pins |

## Verification
The bench measures every strobe interval exactly, cycle by cycle. A sequencer that loaded the wrong count into a phase, or skipped the turnaround, would show a chip-select pulse or a drive window one cycle off. A design that let output enable fall during a write, or drove the bus while chip select was high, would be flagged on the cycle it happened. Requests are held valid while the controller is busy, so accepting during recovery would show up as extra chip-select pulses and a short recovery gap. Written words are read back through a scoreboard and compared with a shadow copy kept by the bench, so a capture on the wrong cycle or a misplaced write edge returns wrong data.

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int AW    = 17,
  parameter int DW    = 8,
  parameter int T_AS  = 1,
  parameter int T_WZ  = 1,
  parameter int T_DS  = 2,
  parameter int T_DH  = 1,
  parameter int T_REC = 2,
  parameter int T_ACC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int M1   = (T_AS > T_WZ) ? T_AS : T_WZ;
  localparam int M2   = (T_DS > T_DH) ? T_DS : T_DH;
  localparam int M3   = (T_REC > T_ACC) ? T_REC : T_ACC;
  localparam int M12  = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M12 > M3) ? M12 : M3;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;

  localparam logic [CW-1:0] L_AS  = CW'(T_AS - 1);
  localparam logic [CW-1:0] L_WZ  = CW'(T_WZ - 1);
  localparam logic [CW-1:0] L_DS  = CW'(T_DS - 1);
  localparam logic [CW-1:0] L_DH  = CW'(T_DH - 1);
  localparam logic [CW-1:0] L_REC = CW'(T_REC - 1);
  localparam logic [CW-1:0] L_ACC = CW'(T_ACC - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ASU, ST_TURN, ST_WDAT, ST_HOLD, ST_RACC, ST_RECV
  } phase_t;

  phase_t          state, state_d;
  logic [CW-1:0]   cnt, cnt_d;
  logic            take, capture;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            ce_q, we_q, oe_q, drv_q;

  assign take    = (state == ST_IDLE) && req_valid;
  assign capture = (state == ST_RACC) && (cnt == '0);

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    if (state == ST_IDLE) begin
      if (req_valid) begin
        state_d = req_write ? ST_ASU : ST_RACC;
        cnt_d   = req_write ? L_AS : L_ACC;
      end
    end else if (cnt != '0) begin
      cnt_d = cnt - 1'b1;
    end else begin
      case (state)
        ST_ASU:  begin state_d = ST_TURN; cnt_d = L_WZ;  end
        ST_TURN: begin state_d = ST_WDAT; cnt_d = L_DS;  end
        ST_WDAT: begin state_d = ST_HOLD; cnt_d = L_DH;  end
        ST_HOLD: begin state_d = ST_RECV; cnt_d = L_REC; end
        ST_RACC: begin state_d = ST_RECV; cnt_d = L_REC; end
        default: begin state_d = ST_IDLE; cnt_d = '0;    end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ce_q     <= 1'b1;
      we_q     <= 1'b1;
      oe_q     <= 1'b1;
      drv_q    <= 1'b0;
    end else begin
      state    <= state_d;
      cnt      <= cnt_d;
      rd_valid <= capture;
      if (capture) rd_data <= sram_dq_in;
      if (take) begin
        addr_q <= req_addr;
        if (req_write) wdata_q <= req_wdata;
      end
      ce_q  <= (state_d == ST_IDLE) || (state_d == ST_RECV);
      we_q  <= !((state_d == ST_TURN) || (state_d == ST_WDAT));
      oe_q  <= (state_d != ST_RACC);
      drv_q <= (state_d == ST_WDAT) || (state_d == ST_HOLD);
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign sram_ce_n   = ce_q;
  assign sram_we_n   = we_q;
  assign sram_oe_n   = oe_q;
  assign sram_dq_oe  = drv_q;
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          drv,
  input logic [AW-1:0] addr,
  input logic          ready,
  input logic          rvalid
);

  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || drv) |-> oe_n);

  assert_turn_before_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> !drv);

  assert_drive_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> !ce_n);

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !$past(ce_n)) |-> $stable(addr));

  assert_recovery_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> (ce_n && !ready));

  assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !ready);

endmodule

bind sram_strobe_seq sram_strobe_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ce_n  (sram_ce_n),
  .we_n  (sram_we_n),
  .oe_n  (sram_oe_n),
  .drv   (sram_dq_oe),
  .addr  (sram_addr),
  .ready (req_ready),
  .rvalid(rd_valid)
);

// File: tb/sim_sram_strobe_seq.sv
module sim_sram_strobe_seq;
  localparam int AW = 8, DW = 16;
  localparam int T_AS = 2, T_WZ = 1, T_DS = 3, T_DH = 2, T_REC = 2, T_ACC = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data, dq_out, dq_in;
  logic ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] s_addr;

  always #10 clk = ~clk;

  sram_strobe_seq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WZ(T_WZ), .T_DS(T_DS),
    .T_DH(T_DH), .T_REC(T_REC), .T_ACC(T_ACC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_ce_n(ce_n), .sram_we_n(we_n),
    .sram_oe_n(oe_n), .sram_addr(s_addr), .sram_dq_out(dq_out),
    .sram_dq_oe(dq_oe), .sram_dq_in(dq_in));

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [DW-1:0] exp_q [$];
  int n_chk = 0, n_err = 0, n_req = 0, ce_falls = 0;

  always @(posedge we_n)
    if (ce_n === 1'b0 && dq_oe === 1'b1) mem[s_addr] <= dq_out;
  assign dq_in = (!ce_n && !oe_n && we_n) ? mem[s_addr] : '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) shadow[a] = d; else exp_q.push_back(shadow[a]);
    n_req++;
    @(negedge clk);
    req_valid = 0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
  endtask

  bit pce = 1, seen = 0, was_wr = 0, bad_a = 0, bad_g = 0;
  int ce_lo, pre, turn, dat, hold, ce_hi, g_lo;
  logic [AW-1:0] a0;

  always @(negedge clk) if (rst_n) begin
    if (!ce_n) begin
      if (pce) begin
        ce_falls++;
        if (seen) chk(ce_hi >= T_REC, "R7 gap", ce_hi, T_REC);
        ce_lo = 0; pre = 0; turn = 0; dat = 0; hold = 0; g_lo = 0;
        was_wr = 0; bad_a = 0; bad_g = 0; a0 = s_addr;
      end
      ce_lo++;
      if (!oe_n) g_lo++;
      if (!we_n) begin
        was_wr = 1;
        if (dq_oe) dat++; else turn++;
      end else if (!was_wr) pre++;
      else if (dq_oe) hold++;
      if (s_addr != a0) bad_a = 1;
      if ((!we_n || dq_oe) && !oe_n) bad_g = 1;
    end else begin
      if (!pce) begin
        seen = 1; ce_hi = 1;
        chk(!bad_a, "R6 addr stable", bad_a, 0);
        if (was_wr) begin
          chk(ce_lo == T_AS+T_WZ+T_DS+T_DH, "R2 ce width", ce_lo, T_AS+T_WZ+T_DS+T_DH);
          chk(pre == T_AS, "R2 ce-to-we", pre, T_AS);
          chk(turn == T_WZ, "R4 turnaround", turn, T_WZ);
          chk(dat == T_DS, "R4 data setup", dat, T_DS);
          chk(hold == T_DH, "R5 data hold", hold, T_DH);
          chk(!bad_g, "R3 oe high in write", bad_g, 0);
          chk(!dq_oe, "R5 bus released", dq_oe, 0);
        end else begin
          chk(ce_lo == T_ACC, "R8 access width", ce_lo, T_ACC);
          chk(g_lo == T_ACC, "R8 oe width", g_lo, T_ACC);
          chk(rd_valid, "R8 valid timing", rd_valid, 1);
        end
      end else ce_hi++;
      if (seen && ce_hi <= T_REC) chk(!req_ready, "R7 ready low", req_ready, 0);
      if (seen && ce_hi == T_REC+1) chk(req_ready, "R7 ready back", req_ready, 1);
      if (dq_oe) chk(0, "R5 drive with ce high", dq_oe, 0);
    end
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected valid", rd_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R10 read data", rd_data, e);
      end
    end
    pce = ce_n;
  end

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n, "R1 strobes in reset", {ce_n, we_n, oe_n}, 3'b111);
    chk(!dq_oe && !rd_valid, "R1 drive/valid in reset", {dq_oe, rd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe, "R1 after release", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    chk(req_ready && !rd_valid, "R1 ready after release", {req_ready, rd_valid}, 2'b10);
    issue(1, 8'h00, 16'h0000);
    issue(1, 8'hFF, 16'hFFFF);
    issue(1, 8'h3C, 16'hA55A);
    issue(0, 8'h3C, 0);
    issue(0, 8'hFF, 0);
    issue(0, 8'h00, 0);
    issue(1, 8'h00, 16'h1234);
    issue(0, 8'h00, 0);
    for (int k = 0; k < 6; k++) issue(1, 8'(k * 37 + 5), 16'(k * 16'h1111 + 7));
    for (int k = 5; k >= 0; k--) issue(0, 8'(k * 37 + 5), 0);
    issue(0, 8'h3C, 0);
    issue(1, 8'h3C, 16'h0F0F);
    issue(0, 8'h3C, 0);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (T_REC + 4) @(negedge clk);
    chk(ce_falls == n_req, "R9 one pulse per request", ce_falls, n_req);
    chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    finish_up();
  end
endmodule